// File: doc/BRIEF.md
# Sticky Status and Interrupt Register Bank

This block is a small bank of software-visible registers that sits behind a plain synchronous register bus. The bus has an address, a read strobe, a write strobe, write data and registered read data. Each register follows one access policy:

- plain control storage;
- a status value copied from hardware through one register stage;
- a live value with no storage;
- a field that loads a boot value on its own once reset ends;
- a field whose write also sends a one-cycle pulse to hardware;
- a scratch field that hardware never uses;
- four sticky event fields.

The four sticky fields differ in three ways. Each one latches on a level or on an edge. Each one is active on a high or a low input. Each one is cleared either by reading it or by writing ones to the bits to be cleared. The two edge-detected sticky fields are interrupt sources. Each has an enable register. Their enabled bits are merged into one registered, active-high interrupt line.

Software polls or services the bank through the bus. Hardware feeds in event, status, live and boot inputs, and takes out the control value, the write pulse and the interrupt. All fields are `W` bits wide. The hardware inputs of the sticky fields arrive packed in one vector, with slice i (bits i*W+W-1 down to i*W) belonging to sticky field i.

Top module: `evt_status_bank`

## Requirements
- R1: After reset every stored field, `ctrl_o`, `strobe_o`, `irq_o` and `rd_data` are zero. A read presents the addressed value on `rd_data` on the clock edge that samples `rd_en`, and `rd_data` holds that value afterwards. Address 0 is a read/write control field driving `ctrl_o`. Addresses 10, 11, 14 and 15 read as zero.
- R2: Address 1 returns `stat_in` as registered one clock earlier. A read in the same cycle that `stat_in` changes returns the old value.
- R3: Address 2 returns `live_in` as sampled at the read edge, with no register stage.
- R4: Sticky field 0 (address 6) sets each bit whose input in slice 0 is high at a clock edge. The bit stays set while the input is low. A read of address 6 clears the whole field.
- R5: Sticky field 1 (address 7) sets each bit whose input in slice 1 is low. Reads leave it unchanged. A write to address 7 clears exactly the bits written as 1.
- R6: Sticky field 2 (address 8) sets a bit on a 0-to-1 change of its slice 2 input, where the previous sample resets to 0. A steady high input does not set the bit again. A read clears the field.
- R7: Sticky field 3 (address 9) sets a bit on a 1-to-0 change of its slice 3 input. It is cleared only by a write of ones to address 9.
- R8: When a set condition and a clear fall on the same bit in the same cycle, the bit ends set.
- R9: Addresses 12 and 13 are read/write enables for sticky fields 2 and 3. `irq_o` is registered and equals the OR, over both fields, of the sticky bits ANDed with their enables.
- R10: Address 3 loads `boot_in` on the first clock edge after reset ends. It ignores later changes of `boot_in`. After that it is read/write.
- R11: A write to address 4 stores the data, which then reads back. The write also drives `strobe_o` with the written data for exactly one cycle after the write edge. `strobe_o` is zero otherwise.
- R12: Address 5 is read/write scratch storage. A write to it changes no output other than what a later read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | W | Write data |
| rd_data | output | W | Registered read data |
| stat_in | input | W | Status value from hardware (registered copy) |
| live_in | input | W | Live value from hardware (no storage) |
| evt_in | input | 4*W | Sticky field inputs, slice i feeds field i |
| boot_in | input | W | Value loaded after reset ends |
| ctrl_o | output | W | Control field value |
| strobe_o | output | W | One-cycle pulse of written strobe data |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
The bench builds the block with its defaults, W = 8 and ADDR_W = 4. Eight bits per field let a single vector mix set, held and cleared bits. That exposes a clear that spills onto the wrong bits, a write-one-to-clear that acts as a full clear, and a polarity mix-up in either latch. With a four-bit address the bench can also reach unmapped words and the unused enable slots.

// File: rtl/evt_status_bank_pkg.sv
// Shared types and address map for the sticky status bank.
// Assumes every address fits in the top-level ADDR_W (at least 4 bits).
package evt_status_bank_pkg;

    typedef enum logic {SRC_LEVEL, SRC_EDGE} src_e;
    typedef enum logic {CLR_READ, CLR_MASK} clr_e;

    typedef struct packed {
        src_e src;
        logic act_high;
        clr_e clr;
        logic is_irq;
    } sticky_cfg_t;

    localparam int NSTICKY = 4;

    // field 3 .. field 0
    localparam sticky_cfg_t [NSTICKY-1:0] STICKY_CFG = {
        sticky_cfg_t'{src: SRC_EDGE,  act_high: 1'b0, clr: CLR_MASK, is_irq: 1'b1},
        sticky_cfg_t'{src: SRC_EDGE,  act_high: 1'b1, clr: CLR_READ, is_irq: 1'b1},
        sticky_cfg_t'{src: SRC_LEVEL, act_high: 1'b0, clr: CLR_MASK, is_irq: 1'b0},
        sticky_cfg_t'{src: SRC_LEVEL, act_high: 1'b1, clr: CLR_READ, is_irq: 1'b0}
    };

    localparam int A_CTRL    = 0;
    localparam int A_STAT    = 1;
    localparam int A_LIVE    = 2;
    localparam int A_BOOT    = 3;
    localparam int A_STROBE  = 4;
    localparam int A_SCRATCH = 5;
    localparam int A_STICKY0 = 6;
    localparam int A_IEN0    = A_STICKY0 + NSTICKY;

endpackage

// File: rtl/sticky_field.sv
// One sticky event field of W bits.
// SRC selects level or edge capture, ACT_HIGH selects polarity, and CLR
// selects clear-on-read (rd_hit) or write-one-to-clear (wr_hit & wr_data).
// A set and a clear in the same cycle leave the bit set.
// Assumes rd_hit and wr_hit are single-cycle bus strobes already decoded.
module sticky_field
    import evt_status_bank_pkg::*;
#(
    parameter int   W        = 8,
    parameter src_e SRC      = SRC_LEVEL,
    parameter logic ACT_HIGH = 1'b1,
    parameter clr_e CLR      = CLR_READ
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_in,
    input  logic         rd_hit,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] val_o
);

    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;

    generate
        if (SRC == SRC_EDGE) begin : g_edge
            logic [W-1:0] prev_q;
            // Keep the previous input sample for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= '0;
                else        prev_q <= src_in;
            end
            assign set_v = ACT_HIGH ? (src_in & ~prev_q) : (prev_q & ~src_in);
        end else begin : g_level
            assign set_v = ACT_HIGH ? src_in : ~src_in;
        end
    endgenerate

    assign clr_v = (CLR == CLR_READ) ? {W{rd_hit}} : ({W{wr_hit}} & wr_data);

    // Sticky storage: clear first, then OR in new events so sets win.
    always_ff @(posedge clk) begin
        if (!rst_n) val_o <= '0;
        else        val_o <= (val_o & ~clr_v) | set_v;
    end

endmodule

// File: rtl/boot_field.sv
// Read/write field that loads boot_in once, on the first clock edge after
// reset ends, and then behaves as ordinary storage.
// Assumes boot_in is stable around the end of reset.
module boot_field #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] boot_in,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] val_o
);

    logic loaded_q;

    // Load once after reset, afterwards accept bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_o    <= '0;
            loaded_q <= 1'b0;
        end else if (!loaded_q) begin
            val_o    <= boot_in;
            loaded_q <= 1'b1;
        end else if (wr_hit) begin
            val_o <= wr_data;
        end
    end

endmodule

// File: rtl/evt_status_bank.sv
// Top of the sticky status and interrupt register bank.
// Decodes the register bus, holds the plain fields, instantiates the sticky
// fields and their enables, registers read data and the combined interrupt.
// Assumes single-cycle rd_en/wr_en strobes and ADDR_W of at least 4.
module evt_status_bank
    import evt_status_bank_pkg::*;
#(
    parameter int W      = 8,
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [W-1:0]         wr_data,
    output logic [W-1:0]         rd_data,
    input  logic [W-1:0]         stat_in,
    input  logic [W-1:0]         live_in,
    input  logic [NSTICKY*W-1:0] evt_in,
    input  logic [W-1:0]         boot_in,
    output logic [W-1:0]         ctrl_o,
    output logic [W-1:0]         strobe_o,
    output logic                 irq_o
);

    logic [W-1:0] stat_q, strobe_q, scratch_q, boot_val, rd_mux;
    logic [NSTICKY-1:0][W-1:0] sticky_val;
    logic [NSTICKY-1:0][W-1:0] ien_val;
    logic [W-1:0] irq_bits;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
        return a == ADDR_W'(target);
    endfunction

    // Plain control, scratch, strobe holding and status copy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o    <= '0;
            scratch_q <= '0;
            strobe_q  <= '0;
            strobe_o  <= '0;
            stat_q    <= '0;
        end else begin
            stat_q   <= stat_in;
            strobe_o <= (wr_en && hit(addr, A_STROBE)) ? wr_data : '0;
            if (wr_en && hit(addr, A_CTRL))    ctrl_o    <= wr_data;
            if (wr_en && hit(addr, A_SCRATCH)) scratch_q <= wr_data;
            if (wr_en && hit(addr, A_STROBE))  strobe_q  <= wr_data;
        end
    end

    boot_field #(.W(W)) u_boot (
        .clk     (clk),
        .rst_n   (rst_n),
        .boot_in (boot_in),
        .wr_hit  (wr_en && hit(addr, A_BOOT)),
        .wr_data (wr_data),
        .val_o   (boot_val)
    );

    generate
        for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
            sticky_field #(
                .W        (W),
                .SRC      (STICKY_CFG[i].src),
                .ACT_HIGH (STICKY_CFG[i].act_high),
                .CLR      (STICKY_CFG[i].clr)
            ) u_field (
                .clk     (clk),
                .rst_n   (rst_n),
                .src_in  (evt_in[i*W +: W]),
                .rd_hit  (rd_en && hit(addr, A_STICKY0 + i)),
                .wr_hit  (wr_en && hit(addr, A_STICKY0 + i)),
                .wr_data (wr_data),
                .val_o   (sticky_val[i])
            );

            if (STICKY_CFG[i].is_irq) begin : g_ien
                logic [W-1:0] ien_q;
                // Interrupt enable storage for this source.
                always_ff @(posedge clk) begin
                    if (!rst_n)                              ien_q <= '0;
                    else if (wr_en && hit(addr, A_IEN0 + i)) ien_q <= wr_data;
                end
                assign ien_val[i] = ien_q;
            end else begin : g_no_ien
                assign ien_val[i] = '0;
            end
        end
    endgenerate

    // Merge enabled interrupt bits across all sources.
    always_comb begin
        irq_bits = '0;
        for (int i = 0; i < NSTICKY; i++) irq_bits |= sticky_val[i] & ien_val[i];
    end

    // Read multiplexer over every mapped address.
    always_comb begin
        rd_mux = '0;
        if (hit(addr, A_CTRL))    rd_mux = ctrl_o;
        if (hit(addr, A_STAT))    rd_mux = stat_q;
        if (hit(addr, A_LIVE))    rd_mux = live_in;
        if (hit(addr, A_BOOT))    rd_mux = boot_val;
        if (hit(addr, A_STROBE))  rd_mux = strobe_q;
        if (hit(addr, A_SCRATCH)) rd_mux = scratch_q;
        for (int i = 0; i < NSTICKY; i++) begin
            if (hit(addr, A_STICKY0 + i)) rd_mux = sticky_val[i];
            if (hit(addr, A_IEN0 + i))    rd_mux = ien_val[i];
        end
    end

    // Registered read data and interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            irq_o   <= 1'b0;
        end else begin
            if (rd_en) rd_data <= rd_mux;
            irq_o <= |irq_bits;
        end
    end

endmodule

// File: rtl/evt_status_bank_chk.sv
// Assertion checker for evt_status_bank, attached through bind.
// Assumes the address map of evt_status_bank_pkg.
module evt_status_bank_chk
    import evt_status_bank_pkg::*;
#(
    parameter int W      = 8,
    parameter int ADDR_W = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         addr,
    input logic                      rd_en,
    input logic                      wr_en,
    input logic [W-1:0]              stat_in,
    input logic [W-1:0]              stat_q,
    input logic [NSTICKY*W-1:0]      evt_in,
    input logic [NSTICKY-1:0][W-1:0] sticky_val,
    input logic [NSTICKY-1:0][W-1:0] ien_val,
    input logic [W-1:0]              strobe_o,
    input logic                      irq_o
);

    logic past_ok;

    // Marks that at least one cycle has passed since reset ended.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_stat_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> stat_q == $past(stat_in));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(A_STICKY0)) |=> sticky_val[0] == $past(evt_in[W-1:0]));

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(A_STICKY0 + 1))
        |=> ($past(sticky_val[1]) & ~sticky_val[1]) == '0);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (sticky_val[0] & $past(evt_in[W-1:0])) == $past(evt_in[W-1:0]));

    assert_irq_merge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> irq_o == $past(|((sticky_val[2] & ien_val[2]) | (sticky_val[3] & ien_val[3]))));

    assert_strobe_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (|strobe_o)) |-> $past(wr_en && addr == ADDR_W'(A_STROBE)));

endmodule

bind evt_status_bank evt_status_bank_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .stat_in    (stat_in),
    .stat_q     (stat_q),
    .evt_in     (evt_in),
    .sticky_val (sticky_val),
    .ien_val    (ien_val),
    .strobe_o   (strobe_o),
    .irq_o      (irq_o)
);

// File: tb/evt_status_bank_test.sv
module evt_status_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          rd_en = 1'b0, wr_en = 1'b0;
    logic [W-1:0]  wr_data = '0, rd_data;
    logic [W-1:0]  stat_in = '0, live_in = '0, boot_in = 8'hA5;
    logic [W-1:0]  ev0 = 8'h00, ev1 = 8'hFF, ev2 = 8'h00, ev3 = 8'hFF;
    logic [W-1:0]  ctrl_o, strobe_o;
    logic          irq_o;
    int            n_chk = 0, n_bad = 0;
    bit            done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_status_bank #(.W(W), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .stat_in(stat_in), .live_in(live_in),
        .evt_in({ev3, ev2, ev1, ev0}), .boot_in(boot_in), .ctrl_o(ctrl_o),
        .strobe_o(strobe_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [W-1:0] d);
        @(negedge clk);
        addr = AW'(a); wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [W-1:0] d);
        @(negedge clk);
        addr = AW'(a); rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        chk("R1 rd_data reset", rd_data, 0);
        chk("R1 ctrl_o reset", ctrl_o, 0);
        chk("R11 strobe_o reset", strobe_o, 0);
        chk("R9 irq_o reset", {7'b0, irq_o}, 0);
        bus_rd(0, v);  chk("R1 ctrl reads zero", v, 0);
        bus_rd(6, v);  chk("R4 sticky0 reset", v, 0);
    endtask

    task automatic t_ctrl();
        logic [W-1:0] v;
        bus_wr(0, 8'h3C);
        chk("R1 ctrl_o follows write", ctrl_o, 8'h3C);
        bus_rd(0, v);  chk("R1 ctrl readback", v, 8'h3C);
        bus_rd(10, v); chk("R1 unmapped 10", v, 0);
        bus_rd(15, v); chk("R1 unmapped 15", v, 0);
        @(negedge clk);
        chk("R1 rd_data held", rd_data, 0);
    endtask

    task automatic t_stat_live();
        logic [W-1:0] v;
        @(negedge clk);
        stat_in = 8'h77; addr = AW'(1); rd_en = 1'b1;
        @(posedge clk); @(negedge clk); rd_en = 1'b0;
        chk("R2 status lags one clock", rd_data, 8'h00);
        bus_rd(1, v); chk("R2 status after lag", v, 8'h77);
        @(negedge clk);
        live_in = 8'h5A; addr = AW'(2); rd_en = 1'b1;
        @(posedge clk); @(negedge clk); rd_en = 1'b0;
        chk("R3 live same cycle", rd_data, 8'h5A);
        live_in = 8'hC1;
        bus_rd(2, v); chk("R3 live follows", v, 8'hC1);
    endtask

    task automatic t_level();
        logic [W-1:0] v;
        @(negedge clk); ev0 = 8'h05;
        @(negedge clk); ev0 = 8'h00;
        @(negedge clk);
        bus_rd(6, v); chk("R4 level high latched", v, 8'h05);
        bus_rd(6, v); chk("R4 cleared by read", v, 8'h00);
        bus_wr(7, 8'hFF);
        @(negedge clk); ev1 = 8'hF6;
        @(negedge clk); ev1 = 8'hFF;
        bus_rd(7, v); chk("R5 level low latched", v, 8'h09);
        bus_rd(7, v); chk("R5 read keeps", v, 8'h09);
        bus_wr(7, 8'h01);
        bus_rd(7, v); chk("R5 mask clears only ones", v, 8'h08);
        bus_wr(7, 8'h08);
        bus_rd(7, v); chk("R5 mask clears rest", v, 8'h00);
    endtask

    task automatic t_set_wins();
        logic [W-1:0] v;
        @(negedge clk); ev0 = 8'h80;
        bus_rd(6, v); chk("R8 read during set", v, 8'h80);
        bus_rd(6, v); chk("R8 set wins over read clear", v, 8'h80);
        ev0 = 8'h00;
        bus_rd(6, v); bus_rd(6, v); chk("R8 clears once input idle", v, 8'h00);
        @(negedge clk); ev1 = 8'hFE;
        bus_wr(7, 8'h01);
        bus_rd(7, v); chk("R8 set wins over mask clear", v, 8'h01);
        ev1 = 8'hFF;
        bus_wr(7, 8'h01);
        bus_rd(7, v); chk("R8 mask clear after idle", v, 8'h00);
    endtask

    task automatic t_edges();
        logic [W-1:0] v;
        @(negedge clk); ev2 = 8'h10;
        @(negedge clk);
        bus_rd(8, v); chk("R6 rising latched", v, 8'h10);
        bus_rd(8, v); chk("R6 steady high no reset", v, 8'h00);
        ev2 = 8'h00;
        @(negedge clk); ev3 = 8'hEF;
        @(negedge clk);
        bus_rd(9, v); chk("R7 falling latched", v, 8'h10);
        bus_rd(9, v); chk("R7 read keeps", v, 8'h10);
        bus_wr(9, 8'h10);
        bus_rd(9, v); chk("R7 mask clears", v, 8'h00);
        ev3 = 8'hFF;
        @(negedge clk);
        bus_rd(9, v); chk("R7 rising input ignored", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [W-1:0] v;
        @(negedge clk); ev2 = 8'h02;
        repeat (3) @(negedge clk);
        chk("R9 disabled source quiet", {7'b0, irq_o}, 0);
        bus_wr(12, 8'h02);
        repeat (2) @(negedge clk);
        chk("R9 enabled source raises irq", {7'b0, irq_o}, 1);
        bus_rd(12, v); chk("R9 enable readback", v, 8'h02);
        bus_rd(8, v);  chk("R6 irq bit read", v, 8'h02);
        repeat (2) @(negedge clk);
        chk("R9 irq drops after clear", {7'b0, irq_o}, 0);
        ev2 = 8'h00;
        bus_wr(13, 8'h01);
        @(negedge clk); ev3 = 8'hFE;
        repeat (3) @(negedge clk);
        chk("R9 falling source raises irq", {7'b0, irq_o}, 1);
        bus_wr(9, 8'h01);
        repeat (2) @(negedge clk);
        chk("R9 irq drops after mask", {7'b0, irq_o}, 0);
        ev3 = 8'hFF;
    endtask

    task automatic t_boot_strobe();
        logic [W-1:0] v;
        bus_rd(3, v); chk("R10 boot value loaded", v, 8'hA5);
        bus_wr(3, 8'h11);
        bus_rd(3, v); chk("R10 boot field writable", v, 8'h11);
        bus_wr(4, 8'h6B);
        chk("R11 strobe pulse data", strobe_o, 8'h6B);
        @(negedge clk);
        chk("R11 strobe one cycle", strobe_o, 8'h00);
        bus_rd(4, v); chk("R11 strobe readback", v, 8'h6B);
        bus_wr(5, 8'hC3);
        chk("R12 scratch no strobe", strobe_o, 8'h00);
        @(negedge clk);
        chk("R12 scratch ctrl unchanged", ctrl_o, 8'h3C);
        chk("R12 scratch no irq", {7'b0, irq_o}, 0);
        bus_rd(5, v); chk("R12 scratch readback", v, 8'hC3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        boot_in = 8'h3C;
        t_reset();
        t_ctrl();
        t_stat_live();
        t_level();
        t_set_wins();
        t_edges();
        t_irq();
        t_boot_strobe();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule